// File: doc/BRIEF.md
# Priority Interrupt Arbiter with Nested and Concurrent Modes

The block collects interrupt requests from a set of sources and decides which one the processor takes next. Each source has a 3-bit priority level. Level 0 is the most urgent and level 7 is the least urgent. A request pulse is latched as pending until that source is acknowledged. When the global enable flag is set and a pending request is eligible, the block raises a one-cycle acknowledge that carries the index of the winning source.

Two arbitration modes are supported. In nested mode, the current priority level (CPL) rises to the level of the request being serviced, and only a strictly more urgent request can preempt that handler. In concurrent mode, the CPL is pinned to the least urgent level for the whole handler. If software re-enables interrupts inside a handler, any pending request can then preempt it, so handlers run in the reverse order of their urgency.

Every acknowledge saves the previous CPL, enable flag and segment selection on an internal context stack. The return strobe restores them, so a nested return gives the outer handler back its own segment selection. The processor side is modelled only as strobes: enable-interrupts and return.

Top module: `irq_arbiter`

## Requirements
- R1: The acknowledged source is the pending, eligible source with the numerically lowest level. Among sources on the same level, the lowest index wins. `ack_id_o` carries that index while `ack_o` is high.
- R2: In concurrent mode (`mode_conc_i`=1), `cpl_o` becomes 7 on every acknowledge and stays 7 until a return.
- R3: In concurrent mode, a pending request of any level is acknowledged as soon as the enable flag is set, even inside a handler. Requests on levels 2, 3, 4 and 5 that arrive together, with the handler re-enabling each time, are acknowledged in the order 2, 3, 4, 5.
- R4: In nested mode, a request is acknowledged only if its level is strictly below `cpl_o`, and `cpl_o` then takes that level. A level-7 request is therefore never taken in nested mode.
- R5: On acknowledge, `seg_isr_o` becomes the inverse of `seg_en_i` (1 = interrupt segment). A return restores the selection that was saved when the returning handler was entered.
- R6: After reset, `cpl_o`=7, `ien_o`=0, `seg_isr_o`=0, `ack_o`=0 and `ovf_o`=0.
- R7: An acknowledge clears `ien_o`. `ei_i` sets it, and a return restores the saved value. An acknowledge takes precedence over `ei_i` in the same cycle, and no acknowledge is issued in a cycle where `iret_i` is high.
- R8: The context stack holds 8 entries. Each acknowledge pushes an entry and each return pops one. A return with an empty stack changes nothing. A push onto a full stack is dropped and sets `ovf_o`, which stays set until reset.
- R9: `ack_o` is a single-cycle pulse. It is driven from the cycle after the cycle in which the request is pending and the enable flag is set. The source's pending bit clears at that same edge, and an unacknowledged request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_SRC | Request pulses, one bit per source |
| prio_i | input | 3*NUM_SRC | Level of source i in bits [3i+2:3i] |
| mode_conc_i | input | 1 | 1 = concurrent mode, 0 = nested mode |
| seg_en_i | input | 1 | 1 = handlers keep the code segment selected |
| ei_i | input | 1 | Enable-interrupts strobe |
| iret_i | input | 1 | Return-from-interrupt strobe |
| ack_o | output | 1 | Acknowledge pulse |
| ack_id_o | output | clog2(NUM_SRC) | Index of the acknowledged source |
| cpl_o | output | 3 | Current priority level |
| ien_o | output | 1 | Global interrupt enable |
| seg_isr_o | output | 1 | 1 = interrupt segment selected |
| ovf_o | output | 1 | Sticky context-stack overflow |

## Verification
A wrong pending bit or picker result shows up at the ports as a wrong `ack_id_o`, a missing `ack_o`, or an extra `ack_o`, one cycle after the enable flag allows arbitration. A corrupt context stack stays hidden until a return. At that point `cpl_o`, `ien_o` and `seg_isr_o` take wrong values on the cycle after the return strobe, and a stale CPL in nested mode can also block a later request indefinitely. For this reason the scenarios unwind every nesting they build and compare all outputs against a behavioural model on each cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] LVL_LOWEST = '1;

  typedef struct packed {
    logic             seg_isr;
    logic             ien;
    logic [LVL_W-1:0] cpl;
  } ctx_t;
endpackage

// File: rtl/irq_pick.sv
module irq_pick
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0]       pend_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  output logic                     vld_o,
  output logic [ID_W-1:0]          id_o,
  output logic [LVL_W-1:0]         lvl_o
);
  logic [LVL_W-1:0] lvl_a [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_lvl
    assign lvl_a[g] = prio_i[g*LVL_W +: LVL_W];
  end

  // strict compare keeps the lowest index among equal levels
  always_comb begin
    vld_o = 1'b0;
    id_o  = '0;
    lvl_o = LVL_LOWEST;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pend_i[i] && (!vld_o || (lvl_a[i] < lvl_o))) begin
        vld_o = 1'b1;
        id_o  = ID_W'(i);
        lvl_o = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/irq_ctx_stack.sv
module irq_ctx_stack
  import irq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  input  ctx_t din_i,
  output ctx_t dout_o,
  output logic empty_o,
  output logic full_o
);
  ctx_t             mem [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [PTR_W-1:0] wr_ptr, top_ptr;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign wr_ptr  = cnt_q[PTR_W-1:0];
  assign top_ptr = PTR_W'(cnt_q - 1'b1);
  assign dout_o  = mem[top_ptr];

  always_comb begin
    cnt_d = cnt_q;
    if (do_push)     cnt_d = cnt_q + 1'b1;
    else if (do_pop) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din_i;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NUM_SRC   = 8,
  parameter int STK_DEPTH = 8,
  localparam int ID_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC-1:0]       req_i,
  input  logic [NUM_SRC*LVL_W-1:0] prio_i,
  input  logic                     mode_conc_i,
  input  logic                     seg_en_i,
  input  logic                     ei_i,
  input  logic                     iret_i,
  output logic                     ack_o,
  output logic [ID_W-1:0]          ack_id_o,
  output logic [LVL_W-1:0]         cpl_o,
  output logic                     ien_o,
  output logic                     seg_isr_o,
  output logic                     ovf_o
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic [LVL_W-1:0]   cpl_q, cpl_d;
  logic               ien_q, ien_d, seg_q, seg_d, ovf_q, ovf_d;
  logic               ack_q, ack_d;
  logic [ID_W-1:0]    id_q, id_d;

  logic               win_vld, eligible, fire, pop, stk_empty, stk_full;
  logic [ID_W-1:0]    win_id;
  logic [LVL_W-1:0]   win_lvl;
  ctx_t               push_ctx, top_ctx;

  irq_pick #(.NUM_SRC(NUM_SRC)) u_pick (
    .pend_i (pend_q),
    .prio_i (prio_i),
    .vld_o  (win_vld),
    .id_o   (win_id),
    .lvl_o  (win_lvl)
  );

  assign push_ctx = '{seg_isr: seg_q, ien: ien_q, cpl: cpl_q};

  irq_ctx_stack #(.DEPTH(STK_DEPTH)) u_stack (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (fire),
    .pop_i   (pop),
    .din_i   (push_ctx),
    .dout_o  (top_ctx),
    .empty_o (stk_empty),
    .full_o  (stk_full)
  );

  assign eligible = mode_conc_i || (win_lvl < cpl_q);
  assign fire     = ien_q && win_vld && eligible && !iret_i;
  assign pop      = iret_i && !stk_empty;

  always_comb begin
    pend_d = pend_q | req_i;
    cpl_d  = cpl_q;
    ien_d  = ien_q;
    seg_d  = seg_q;
    ovf_d  = ovf_q;
    ack_d  = fire;
    id_d   = id_q;
    if (fire) begin
      pend_d[win_id] = 1'b0;
      cpl_d          = mode_conc_i ? LVL_LOWEST : win_lvl;
      ien_d          = 1'b0;
      seg_d          = !seg_en_i;
      ovf_d          = ovf_q || stk_full;
      id_d           = win_id;
    end else if (pop) begin
      cpl_d = top_ctx.cpl;
      ien_d = top_ctx.ien;
      seg_d = top_ctx.seg_isr;
    end else if (ei_i) begin
      ien_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pend_q <= '0;
      cpl_q  <= LVL_LOWEST;
      ien_q  <= 1'b0;
      seg_q  <= 1'b0;
      ovf_q  <= 1'b0;
      ack_q  <= 1'b0;
      id_q   <= '0;
    end else begin
      pend_q <= pend_d;
      cpl_q  <= cpl_d;
      ien_q  <= ien_d;
      seg_q  <= seg_d;
      ovf_q  <= ovf_d;
      ack_q  <= ack_d;
      id_q   <= id_d;
    end
  end

  assign ack_o     = ack_q;
  assign ack_id_o  = id_q;
  assign cpl_o     = cpl_q;
  assign ien_o     = ien_q;
  assign seg_isr_o = seg_q;
  assign ovf_o     = ovf_q;
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk
  import irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             mode_conc_i,
  input logic             ack_o,
  input logic [LVL_W-1:0] cpl_o,
  input logic             ien_o,
  input logic             ovf_o
);
  AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o); // R9

  AST_ACK_CLR_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> !ien_o); // R7

  AST_CONC_CPL: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && $past(mode_conc_i)) |-> (cpl_o == LVL_LOWEST)); // R2

  AST_NEST_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !$past(mode_conc_i)) |-> (cpl_o < $past(cpl_o))); // R4

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_o) |-> ovf_o); // R8
endmodule

bind irq_arbiter irq_arbiter_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_conc_i (mode_conc_i),
  .ack_o       (ack_o),
  .cpl_o       (cpl_o),
  .ien_o       (ien_o),
  .ovf_o       (ovf_o)
);

// File: tb/tb_irq_arbiter.sv
`timescale 1ns/1ps
module tb_irq_arbiter;
  localparam int NS = 8;
  localparam int IW = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [NS-1:0]   req_i;
  logic [NS*3-1:0] prio_i;
  logic            mode_conc_i, seg_en_i, ei_i, iret_i;
  logic            ack_o, ien_o, seg_isr_o, ovf_o;
  logic [IW-1:0]   ack_id_o;
  logic [2:0]      cpl_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  irq_arbiter #(.NUM_SRC(NS), .STK_DEPTH(8)) dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .prio_i(prio_i),
    .mode_conc_i(mode_conc_i), .seg_en_i(seg_en_i), .ei_i(ei_i),
    .iret_i(iret_i), .ack_o(ack_o), .ack_id_o(ack_id_o), .cpl_o(cpl_o),
    .ien_o(ien_o), .seg_isr_o(seg_isr_o), .ovf_o(ovf_o)
  );

  // ---------------- behavioural reference model ----------------
  bit [NS-1:0] m_pend;
  int          m_cpl, m_id;
  bit          m_ien, m_seg, m_ovf, m_ack;
  int          m_stk[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = '0; m_cpl = 7; m_ien = 0; m_seg = 0; m_ovf = 0;
      m_ack = 0; m_id = 0; m_stk.delete();
    end else begin
      int best, bestl, ctx;
      bit fire, pop;
      best = -1; bestl = 8;
      for (int i = 0; i < NS; i++)
        if (m_pend[i] && int'(prio_i[i*3 +: 3]) < bestl) begin
          best = i; bestl = int'(prio_i[i*3 +: 3]);
        end
      fire = m_ien && (best >= 0) && (mode_conc_i || bestl < m_cpl) && !iret_i;
      pop  = iret_i && (m_stk.size() > 0);
      m_pend = m_pend | req_i;
      m_ack = fire;
      if (fire) begin
        m_pend[best] = 1'b0;
        if (m_stk.size() < 8) m_stk.push_back(m_cpl | (int'(m_ien) << 3) | (int'(m_seg) << 4));
        else m_ovf = 1;
        m_cpl = mode_conc_i ? 7 : bestl;
        m_ien = 0;
        m_seg = !seg_en_i;
        m_id  = best;
      end else if (pop) begin
        ctx   = m_stk.pop_back();
        m_cpl = ctx & 7;
        m_ien = ctx[3];
        m_seg = ctx[4];
      end else if (ei_i) begin
        m_ien = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R9 ack_o vs model", int'(ack_o), int'(m_ack));
      if (m_ack) chk("R1 ack_id_o vs model", int'(ack_id_o), m_id);
      chk("R2/R4 cpl_o vs model", int'(cpl_o), m_cpl);
      chk("R7 ien_o vs model", int'(ien_o), int'(m_ien));
      chk("R5 seg_isr_o vs model", int'(seg_isr_o), int'(m_seg));
      chk("R8 ovf_o vs model", int'(ovf_o), int'(m_ovf));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_reset();
    rst_n = 1'b0; req_i = '0; ei_i = 0; iret_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic set_prio(input int src, input int lvl);
    prio_i[src*3 +: 3] = 3'(lvl);
  endtask

  task automatic pulse_req(input logic [NS-1:0] m);
    req_i = m; @(negedge clk); req_i = '0;
  endtask

  task automatic pulse_ei();
    ei_i = 1; @(negedge clk); ei_i = 0;
  endtask

  task automatic pulse_iret();
    iret_i = 1; @(negedge clk); iret_i = 0;
  endtask

  task automatic wait_ack(input string tag, input int exp_id);
    bit seen = 0;
    for (int k = 0; k < 30 && !seen; k++) begin
      if (ack_o) seen = 1;
      else @(negedge clk);
    end
    chk({tag, " ack seen"}, int'(seen), 1);
    if (seen) chk({tag, " ack id"}, int'(ack_id_o), exp_id);
  endtask

  task automatic no_ack(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, int'(ack_o), 0);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    prio_i = '1; mode_conc_i = 1; seg_en_i = 0;
    do_reset();

    // R6 reset state
    chk("R6 cpl", int'(cpl_o), 7);
    chk("R6 ien", int'(ien_o), 0);
    chk("R6 seg", int'(seg_isr_o), 0);
    chk("R6 ack", int'(ack_o), 0);
    chk("R6 ovf", int'(ovf_o), 0);

    // R3 / R2 / R5 concurrent nesting with re-enable
    for (int s = 2; s <= 5; s++) set_prio(s, s);
    pulse_ei();
    pulse_req(8'b0011_1100);
    wait_ack("R1 first of 2..5", 2);
    chk("R2 cpl pinned", int'(cpl_o), 7);
    chk("R7 ack clears ien", int'(ien_o), 0);
    chk("R5 interrupt segment", int'(seg_isr_o), 1);
    @(negedge clk);
    pulse_ei(); wait_ack("R3 preempt by 3", 3);
    @(negedge clk);
    pulse_ei(); wait_ack("R3 preempt by 4", 4);
    @(negedge clk);
    pulse_ei(); wait_ack("R3 preempt by 5", 5);
    @(negedge clk);
    pulse_iret();
    chk("R5 inner return keeps isr seg", int'(seg_isr_o), 1);
    chk("R7 return restores ien", int'(ien_o), 1);
    pulse_iret(); pulse_iret(); pulse_iret();
    chk("R5 main segment restored", int'(seg_isr_o), 0);
    chk("R2 cpl main", int'(cpl_o), 7);
    pulse_iret();
    chk("R8 iret on empty ignored", int'(cpl_o), 7);

    // R4 nested mode
    do_reset();
    mode_conc_i = 0; prio_i = '1;
    set_prio(0, 3); set_prio(1, 3); set_prio(6, 1); set_prio(7, 7);
    pulse_ei();
    pulse_req(8'b0000_0011);
    wait_ack("R1 tie lowest index", 0);
    chk("R4 cpl raised", int'(cpl_o), 3);
    @(negedge clk);
    pulse_ei();
    no_ack("R4 equal level blocked", 6);
    pulse_req(8'b0100_0000);
    wait_ack("R4 higher preempts", 6);
    chk("R4 cpl 1", int'(cpl_o), 1);
    @(negedge clk);
    pulse_iret();
    chk("R4 cpl back to 3", int'(cpl_o), 3);
    no_ack("R4 still blocked", 4);
    pulse_iret();
    wait_ack("R9 pending held", 1);
    @(negedge clk);
    pulse_iret();
    pulse_req(8'b1000_0000);
    no_ack("R4 level 7 nested", 6);
    mode_conc_i = 1;
    wait_ack("R4 level 7 concurrent", 7);
    @(negedge clk);
    pulse_iret();

    // R5 segment enable set
    do_reset();
    seg_en_i = 1; prio_i = '1; set_prio(0, 0);
    pulse_ei(); pulse_req(8'b1);
    wait_ack("R5 seg_en", 0);
    chk("R5 code segment kept", int'(seg_isr_o), 0);
    @(negedge clk);
    pulse_iret();

    // R8 overflow
    do_reset();
    seg_en_i = 0;
    pulse_ei();
    for (int k = 0; k < 9; k++) begin
      pulse_req(8'b1);
      wait_ack("R8 ack chain", 0);
      if (k == 7) chk("R8 no ovf at 8", int'(ovf_o), 0);
      @(negedge clk);
      pulse_ei();
    end
    chk("R8 ovf at 9", int'(ovf_o), 1);
    for (int k = 0; k < 10; k++) pulse_iret();
    chk("R8 seg after unwind", int'(seg_isr_o), 0);
    chk("R8 ovf sticky", int'(ovf_o), 1);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule